// File: doc/BRIEF.md
# Sequence-Unlocked Clock Configuration Registers

This block is a small register set on an APB bus that holds the settings for a clock generator. There are two settings registers. The control register carries an enable bit and a connect bit. The configuration register carries a multiplier select field and a pre-divider select field. Software can write both registers at any time, but those writes only change a staged copy. The copy that actually drives the clock generator is loaded from the staged copy when a two-word unlock sequence arrives on a feed register. Any break in that sequence throws the load away without reporting it.

A power-down input turns the generator off and disconnects it. Leaving power-down does not bring back the earlier state: software must stage its settings again and unlock them. A connect request is only honoured when the generator was already enabled before that unlock, so one unlock can never both enable and connect it. The bus side has no wait states and no error response.

A status register reads back the active settings. The effective multiplier (select + 1) and the effective pre-divider (select + 1) are also driven out ready for use.

Top module: `clkcfg_regs`

## Requirements
- R1: After reset, the staged registers, the active registers and every output are zero, and every register reads as zero.
- R2: Word offset 0x0 (control, bit 0 enable, bit 1 connect) and 0x4 (configuration, bits 14:0 multiplier select, bits 20:16 pre-divider select) store the written fields and read them back at the same positions, with other bits reading zero. Writing them does not change any active output.
- R3: A write of the word 0x000000AA to the feed offset 0x8, followed by the very next transfer being a write of 0x00000055 to the feed offset, loads control and configuration into the active registers together on the clock edge that ends the second write. A repeated 0xAA write re-arms, so 0xAA, 0xAA, 0x55 also loads.
- R4: A feed write of any other word, including one with non-zero bits above bit 7, cancels the sequence. A 0x55 write that does not directly follow a 0xAA write loads nothing. A cancelled sequence leaves every active output unchanged.
- R5: The sequence is cancelled by any transfer between the two feed writes (a read or a write, at any offset) and by any clock cycle with select low between them.
- R6: The feed offset always reads as zero, and feed writes never change the staged values. Writes to the status offset have no effect.
- R7: The status offset 0xC reads the active values: bit 0 enable, bit 1 connect, bits 12:8 pre-divider select, bits 30:16 multiplier select, all other bits zero.
- R8: An unlock sets the active connect bit only when staged enable, staged connect and the active enable from before that unlock are all 1. Otherwise it clears active connect.
- R9: A clock edge with power-down high clears active enable and active connect. Active configuration is kept, and it is still loaded if an unlock completes on that same edge.
- R10: After power-down falls, active enable and connect stay zero until a new unlock loads them.
- R11: The multiplier output equals the active multiplier select plus one, and the pre-divider output equals the active pre-divider select plus one (1 to 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pwr_down | input | 1 | Power-down request |
| gen_en | output | 1 | Active enable |
| gen_conn | output | 1 | Active connect |
| gen_msel | output | 15 | Active multiplier select |
| gen_nsel | output | 5 | Active pre-divider select |
| gen_mult | output | 16 | Effective multiplier, select + 1 |
| gen_prediv | output | 6 | Effective pre-divider, select + 1 |

## Verification
The finishing 0x55 feed write and a power-down request can land on the same clock edge. In that case the configuration must load while enable and connect are forced low. The bench provokes this with a directed unlock whose second write carries power-down high. Random stimulus also raises power-down on some access phases and completes some feed pairs while it is high. A bench model applies the load first and the power-down clear after it, and it is checked against the outputs and the status readback.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
package clkcfg_pkg;

    localparam int DATA_W = 32;
    localparam int MSEL_W = 15;
    localparam int DIV_MAX = 32;
    localparam int NSEL_W = $clog2(DIV_MAX);

    // register word selector: paddr[3:2]
    localparam int SEL_LSB = 2;
    localparam int SEL_W   = 2;

    // field positions in configuration and status words
    localparam int CFG_MSEL_LSB  = 0;
    localparam int CFG_NSEL_LSB  = 16;
    localparam int STAT_EN_BIT   = 0;
    localparam int STAT_CONN_BIT = 1;
    localparam int STAT_NSEL_LSB = 8;
    localparam int STAT_MSEL_LSB = 16;

    localparam logic [DATA_W-1:0] KEY_ARM    = 32'h0000_00AA;
    localparam logic [DATA_W-1:0] KEY_COMMIT = 32'h0000_0055;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        REG_CTL  = 2'd0,
        REG_CFG  = 2'd1,
        REG_FEED = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic conn;
        logic en;
    } ctl_t;

    typedef struct packed {
        logic [NSEL_W-1:0] nsel;
        logic [MSEL_W-1:0] msel;
    } cfg_t;

    function automatic word_t pack_ctl(input ctl_t c);
        word_t w;
        w = '0;
        w[STAT_EN_BIT]   = c.en;
        w[STAT_CONN_BIT] = c.conn;
        return w;
    endfunction

    function automatic word_t pack_cfg(input cfg_t c);
        word_t w;
        w = '0;
        w[CFG_MSEL_LSB +: MSEL_W] = c.msel;
        w[CFG_NSEL_LSB +: NSEL_W] = c.nsel;
        return w;
    endfunction

    function automatic word_t pack_status(input ctl_t c, input cfg_t g);
        word_t w;
        w = '0;
        w[STAT_EN_BIT]   = c.en;
        w[STAT_CONN_BIT] = c.conn;
        w[STAT_NSEL_LSB +: NSEL_W] = g.nsel;
        w[STAT_MSEL_LSB +: MSEL_W] = g.msel;
        return w;
    endfunction

    function automatic logic [MSEL_W:0] eff_mult(input logic [MSEL_W-1:0] f);
        return {1'b0, f} + (MSEL_W+1)'(1);
    endfunction

    function automatic logic [NSEL_W:0] eff_prediv(input logic [NSEL_W-1:0] f);
        return {1'b0, f} + (NSEL_W+1)'(1);
    endfunction

endpackage

// File: rtl/clkcfg_apb_decode.sv
`timescale 1ns/1ps
module clkcfg_apb_decode
    import clkcfg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  word_t             pwdata,
    output logic              acc,
    output logic              hit,
    output reg_sel_e          sel,
    output logic              wr_ctl,
    output logic              wr_cfg,
    output logic              wr_feed,
    output logic              key_arm,
    output logic              key_commit
);

    localparam int TOP_LSB = SEL_LSB + SEL_W;

    logic upper_ok;
    logic align_ok;

    // Address bits above the register selector must be zero for a hit.
    generate
        if (ADDR_W > TOP_LSB) begin : g_wide
            assign upper_ok = (paddr[ADDR_W-1:TOP_LSB] == '0);
        end else begin : g_narrow
            assign upper_ok = 1'b1;
        end
    endgenerate

    assign align_ok = (paddr[SEL_LSB-1:0] == '0);
    assign hit      = psel && upper_ok && align_ok;
    assign sel      = reg_sel_e'(paddr[SEL_LSB +: SEL_W]);
    assign acc      = psel && penable;

    always_comb begin
        wr_ctl  = 1'b0;
        wr_cfg  = 1'b0;
        wr_feed = 1'b0;
        if (acc && pwrite && hit) begin
            case (sel)
                REG_CTL:  wr_ctl  = 1'b1;
                REG_CFG:  wr_cfg  = 1'b1;
                REG_FEED: wr_feed = 1'b1;
                default:  ;
            endcase
        end
    end

    // The whole word is compared: stray upper bits spoil the key.
    assign key_arm    = (pwdata == KEY_ARM);
    assign key_commit = (pwdata == KEY_COMMIT);

endmodule

// File: rtl/clkcfg_feed_seq.sv
`timescale 1ns/1ps
module clkcfg_feed_seq (
    input  logic clk,
    input  logic rst,
    input  logic psel,
    input  logic acc,
    input  logic wr_feed,
    input  logic key_arm,
    input  logic key_commit,
    output logic commit
);

    logic armed;

    // Armed lives through exactly one setup phase; any access
    // re-evaluates it, an idle cycle drops it.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (acc) begin
            armed <= wr_feed && key_arm;
        end else if (!psel) begin
            armed <= 1'b0;
        end
    end

    assign commit = acc && wr_feed && key_commit && armed;

endmodule

// File: rtl/clkcfg_active_regs.sv
`timescale 1ns/1ps
module clkcfg_active_regs
    import clkcfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic pwr_down,
    input  ctl_t stg_ctl,
    input  cfg_t stg_cfg,
    output ctl_t act_ctl,
    output cfg_t act_cfg
);

    ctl_t nxt_ctl;

    // Load first, then power-down overrides the control half.
    always_comb begin
        nxt_ctl = act_ctl;
        if (commit) begin
            nxt_ctl.en   = stg_ctl.en;
            nxt_ctl.conn = stg_ctl.conn && stg_ctl.en && act_ctl.en;
        end
        if (pwr_down) begin
            nxt_ctl.en   = 1'b0;
            nxt_ctl.conn = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_ctl <= '0;
            act_cfg <= '0;
        end else begin
            act_ctl <= nxt_ctl;
            if (commit) begin
                act_cfg <= stg_cfg;
            end
        end
    end

endmodule

// File: rtl/clkcfg_regs.sv
`timescale 1ns/1ps
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [DATA_W-1:0]   pwdata,
    output logic [DATA_W-1:0]   prdata,
    input  logic                pwr_down,
    output logic                gen_en,
    output logic                gen_conn,
    output logic [MSEL_W-1:0]   gen_msel,
    output logic [NSEL_W-1:0]   gen_nsel,
    output logic [MSEL_W:0]     gen_mult,
    output logic [NSEL_W:0]     gen_prediv
);

    logic     acc;
    logic     hit;
    reg_sel_e sel;
    logic     wr_ctl;
    logic     wr_cfg;
    logic     wr_feed;
    logic     key_arm;
    logic     key_commit;
    logic     feed_commit;

    ctl_t stg_ctl;
    cfg_t stg_cfg;
    ctl_t act_ctl;
    cfg_t act_cfg;

    clkcfg_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .acc        (acc),
        .hit        (hit),
        .sel        (sel),
        .wr_ctl     (wr_ctl),
        .wr_cfg     (wr_cfg),
        .wr_feed    (wr_feed),
        .key_arm    (key_arm),
        .key_commit (key_commit)
    );

    clkcfg_feed_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .psel       (psel),
        .acc        (acc),
        .wr_feed    (wr_feed),
        .key_arm    (key_arm),
        .key_commit (key_commit),
        .commit     (feed_commit)
    );

    // Staged copies: written freely, never touched by feed or power-down.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_ctl <= '0;
            stg_cfg <= '0;
        end else begin
            if (wr_ctl) begin
                stg_ctl.en   <= pwdata[STAT_EN_BIT];
                stg_ctl.conn <= pwdata[STAT_CONN_BIT];
            end
            if (wr_cfg) begin
                stg_cfg.msel <= pwdata[CFG_MSEL_LSB +: MSEL_W];
                stg_cfg.nsel <= pwdata[CFG_NSEL_LSB +: NSEL_W];
            end
        end
    end

    clkcfg_active_regs u_act (
        .clk      (clk),
        .rst      (rst),
        .commit   (feed_commit),
        .pwr_down (pwr_down),
        .stg_ctl  (stg_ctl),
        .stg_cfg  (stg_cfg),
        .act_ctl  (act_ctl),
        .act_cfg  (act_cfg)
    );

    always_comb begin
        prdata = '0;
        if (hit && !pwrite) begin
            case (sel)
                REG_CTL:  prdata = pack_ctl(stg_ctl);
                REG_CFG:  prdata = pack_cfg(stg_cfg);
                REG_STAT: prdata = pack_status(act_ctl, act_cfg);
                default:  prdata = '0;
            endcase
        end
    end

    assign gen_en     = act_ctl.en;
    assign gen_conn   = act_ctl.conn;
    assign gen_msel   = act_cfg.msel;
    assign gen_nsel   = act_cfg.nsel;
    assign gen_mult   = eff_mult(act_cfg.msel);
    assign gen_prediv = eff_prediv(act_cfg.nsel);

endmodule

// File: rtl/clkcfg_regs_chk.sv
`timescale 1ns/1ps
module clkcfg_regs_chk
    import clkcfg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input word_t             pwdata,
    input word_t             prdata,
    input logic              pwr_down,
    input logic              gen_en,
    input logic              gen_conn,
    input logic [MSEL_W-1:0] gen_msel,
    input logic [NSEL_W-1:0] gen_nsel,
    input logic              commit
);

    localparam logic [ADDR_W-1:0] FEED_ADDR = ADDR_W'(8);

    p_commit_src_r3: assert property (@(posedge clk) disable iff (rst)
        commit |-> (psel && penable && pwrite && paddr == FEED_ADDR && pwdata == KEY_COMMIT));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!commit && !pwr_down) |=> ($stable(gen_msel) && $stable(gen_nsel)
                                    && $stable(gen_en) && $stable(gen_conn)));

    p_feed_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && paddr == FEED_ADDR) |-> (prdata == '0));

    p_conn_guard_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(gen_conn) |-> $past(gen_en));

    p_pd_off_r9: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (!gen_en && !gen_conn));

    p_wake_no_restore_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_down) |-> (!gen_en && !gen_conn));

endmodule

bind clkcfg_regs clkcfg_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .pwr_down (pwr_down),
    .gen_en   (gen_en),
    .gen_conn (gen_conn),
    .gen_msel (gen_msel),
    .gen_nsel (gen_nsel),
    .commit   (feed_commit)
);

// File: tb/tb_clkcfg_regs.sv
`timescale 1ns/1ps
module tb_clkcfg_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pwr_down = 1'b0;
    logic        gen_en;
    logic        gen_conn;
    logic [14:0] gen_msel;
    logic [4:0]  gen_nsel;
    logic [15:0] gen_mult;
    logic [5:0]  gen_prediv;

    always #4 clk = ~clk;

    clkcfg_regs dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pwr_down(pwr_down),
        .gen_en(gen_en), .gen_conn(gen_conn), .gen_msel(gen_msel), .gen_nsel(gen_nsel),
        .gen_mult(gen_mult), .gen_prediv(gen_prediv)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model
    bit          m_se, m_sc, m_ae, m_ac, m_armed;
    logic [14:0] m_sm, m_am;
    logic [4:0]  m_sn, m_an;

    localparam logic [1:0] S_CTL = 2'd0, S_CFG = 2'd1, S_FEED = 2'd2, S_STAT = 2'd3;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [1:0] s);
        case (s)
            S_CTL:   return {30'd0, m_sc, m_se};
            S_CFG:   return {11'd0, m_sn, 1'b0, m_sm};
            S_STAT:  return {1'b0, m_am, 3'd0, m_an, 6'd0, m_ac, m_ae};
            default: return 32'd0;
        endcase
    endfunction

    function automatic void model_access(input logic [1:0] s, input bit wr,
                                         input logic [31:0] d, input bit pd);
        if (wr && s == S_FEED) begin
            if (d == 32'hAA) begin
                m_armed = 1'b1;
            end else if (d == 32'h55 && m_armed) begin
                m_ac = m_sc && m_se && m_ae;
                m_ae = m_se;
                m_am = m_sm;
                m_an = m_sn;
                m_armed = 1'b0;
            end else begin
                m_armed = 1'b0;
            end
        end else begin
            m_armed = 1'b0;
            if (wr && s == S_CTL) begin
                m_se = d[0];
                m_sc = d[1];
            end
            if (wr && s == S_CFG) begin
                m_sm = d[14:0];
                m_sn = d[20:16];
            end
        end
        if (pd) begin
            m_ae = 1'b0;
            m_ac = 1'b0;
        end
    endfunction

    task automatic check_outs(input string tag);
        chk({tag, " en"},     {31'd0, gen_en},     {31'd0, m_ae});
        chk({tag, " conn"},   {31'd0, gen_conn},   {31'd0, m_ac});
        chk({tag, " msel"},   {17'd0, gen_msel},   {17'd0, m_am});
        chk({tag, " nsel"},   {27'd0, gen_nsel},   {27'd0, m_an});
        chk({tag, " R11 mult"},   {16'd0, gen_mult},   32'(m_am) + 32'd1);
        chk({tag, " R11 prediv"}, {26'd0, gen_prediv}, 32'(m_an) + 32'd1);
    endtask

    // One APB transfer; psel stays high afterwards so the next call is back-to-back.
    task automatic xfer(input logic [1:0] s, input bit wr, input logic [31:0] d,
                        input bit pd, input string tag);
        @(negedge clk);
        check_outs(tag);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = {s, 2'b00}; pwdata = d;
        pwr_down = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        pwr_down = pd;
        #1;
        if (!wr) chk({tag, " read"}, prdata, model_read(s));
        model_access(s, wr, d, pd);
    endtask

    task automatic idle(input bit pd, input string tag);
        @(negedge clk);
        check_outs(tag);
        psel = 1'b0; penable = 1'b0; pwr_down = pd;
        m_armed = 1'b0;
        if (pd) begin
            m_ae = 1'b0;
            m_ac = 1'b0;
        end
    endtask

    task automatic rd(input logic [1:0] s, input string tag);
        xfer(s, 1'b0, 32'd0, 1'b0, tag);
    endtask

    task automatic feed_pair(input bit pd, input string tag);
        xfer(S_FEED, 1'b1, 32'hAA, 1'b0, tag);
        xfer(S_FEED, 1'b1, 32'h55, pd, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        {m_se, m_sc, m_ae, m_ac, m_armed} = '0;
        m_sm = '0; m_am = '0; m_sn = '0; m_an = '0;
        seed_v = $urandom(32'h00C1_0C4E);
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        idle(1'b0, "R1 reset");
        rd(S_CTL, "R1 ctl");
        rd(S_CFG, "R1 cfg");
        rd(S_FEED, "R1 feed");
        rd(S_STAT, "R1 stat");
        idle(1'b0, "R1 outs");

        // R2 staging only
        xfer(S_CTL, 1'b1, 32'hFFFF_FFFF, 1'b0, "R2");
        xfer(S_CFG, 1'b1, 32'h0002_0005, 1'b0, "R2");
        rd(S_CTL, "R2 ctl");
        rd(S_CFG, "R2 cfg");
        idle(1'b0, "R2 active untouched");

        // R3 unlock, R8 first unlock cannot connect
        feed_pair(1'b0, "R3");
        idle(1'b0, "R3 R8 after unlock");
        chk("R8 conn held low", {31'd0, gen_conn}, 32'd0);
        chk("R11 mult literal", {16'd0, gen_mult}, 32'd6);
        chk("R11 prediv literal", {26'd0, gen_prediv}, 32'd3);
        rd(S_STAT, "R7 status");
        feed_pair(1'b0, "R8 second");
        idle(1'b0, "R8 connect now");
        chk("R8 conn set", {31'd0, gen_conn}, 32'd1);

        // R4 bad keys
        xfer(S_CFG, 1'b1, 32'h001F_7FFF, 1'b0, "R4");
        xfer(S_FEED, 1'b1, 32'hAA, 1'b0, "R4");
        xfer(S_FEED, 1'b1, 32'h56, 1'b0, "R4");
        xfer(S_FEED, 1'b1, 32'h155, 1'b0, "R4");
        xfer(S_FEED, 1'b1, 32'h1AA, 1'b0, "R4");
        xfer(S_FEED, 1'b1, 32'h55, 1'b0, "R4");
        xfer(S_FEED, 1'b1, 32'h55, 1'b0, "R4");
        idle(1'b0, "R4 no load");
        chk("R4 msel kept", {17'd0, gen_msel}, 32'd5);

        // R5 interrupted sequences
        xfer(S_FEED, 1'b1, 32'hAA, 1'b0, "R5");
        idle(1'b0, "R5");
        xfer(S_FEED, 1'b1, 32'h55, 1'b0, "R5 after idle");
        xfer(S_FEED, 1'b1, 32'hAA, 1'b0, "R5");
        rd(S_CTL, "R5 read between");
        xfer(S_FEED, 1'b1, 32'h55, 1'b0, "R5");
        xfer(S_FEED, 1'b1, 32'hAA, 1'b0, "R5");
        xfer(S_CTL, 1'b1, 32'h3, 1'b0, "R5 write between");
        xfer(S_FEED, 1'b1, 32'h55, 1'b0, "R5");
        idle(1'b0, "R5 no load");
        chk("R5 msel kept", {17'd0, gen_msel}, 32'd5);

        // R3 re-arm
        xfer(S_FEED, 1'b1, 32'hAA, 1'b0, "R3 rearm");
        feed_pair(1'b0, "R3 rearm");
        idle(1'b0, "R3 rearm loaded");
        chk("R3 msel loaded", {17'd0, gen_msel}, 32'h7FFF);

        // R6 feed and status writes
        xfer(S_FEED, 1'b1, 32'h0000_0000, 1'b0, "R6");
        xfer(S_STAT, 1'b1, 32'h0000_0000, 1'b0, "R6");
        rd(S_CTL, "R6 ctl");
        rd(S_CFG, "R6 cfg");
        rd(S_FEED, "R6 feed");
        rd(S_STAT, "R6 stat");

        // R9 power-down, R10 no restore
        idle(1'b1, "R9");
        idle(1'b0, "R9 cleared");
        chk("R9 en", {31'd0, gen_en}, 32'd0);
        chk("R9 msel kept", {17'd0, gen_msel}, 32'h7FFF);
        idle(1'b0, "R10");
        idle(1'b0, "R10 still off");
        chk("R10 en", {31'd0, gen_en}, 32'd0);
        xfer(S_CFG, 1'b1, 32'h0004_0009, 1'b0, "R10");
        feed_pair(1'b0, "R10 reenable");
        idle(1'b0, "R10 R8 enabled only");
        chk("R10 en back", {31'd0, gen_en}, 32'd1);
        chk("R8 no connect after wake", {31'd0, gen_conn}, 32'd0);

        // R9 unlock and power-down on same edge
        xfer(S_CFG, 1'b1, 32'h0007_0011, 1'b0, "R9");
        feed_pair(1'b1, "R9 same edge");
        idle(1'b0, "R9 same edge");
        chk("R9 same-edge en", {31'd0, gen_en}, 32'd0);
        chk("R9 same-edge msel", {17'd0, gen_msel}, 32'h11);
        rd(S_STAT, "R7 R9 stat");

        // random mix
        for (int i = 0; i < 1500; i++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0: xfer(S_CTL, 1'b1, $urandom, 1'b0, "R2 rnd");
                1: xfer(S_CFG, 1'b1, $urandom, 1'b0, "R2 rnd");
                2, 3: feed_pair($urandom_range(0, 5) == 0, "R3 R9 rnd");
                4: xfer(S_FEED, 1'b1, 32'hAA, 1'b0, "R5 rnd");
                5: xfer(S_FEED, 1'b1, 32'h55, 1'b0, "R4 rnd");
                6: xfer(S_FEED, 1'b1, ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 255)),
                        1'b0, "R4 rnd");
                7: rd(2'($urandom_range(0, 3)), "R6 R7 rnd");
                8: idle(1'b0, "R5 rnd");
                default: idle(1'b1, "R9 R10 rnd");
            endcase
        end
        idle(1'b0, "final");
        idle(1'b0, "final");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule